// File: doc/BRIEF.md
# System Control Register Bank

This block is a small word-addressed register file that sits on a 32-bit processor bus and gathers the odds and ends of system control. It keeps the general-purpose output and interrupt-enable words, a scratch word, a sticky debug lock flag and a set of read-only words that identify the system (strapping inputs, clock rate, feature bits and a system identifier). The bus presents a byte address. Bits [6:2] select one of 32 word slots.

Some writes do more than store data. A write of the halt code to the command slot sends a one-cycle halt request. Any write to the identifier slot sends a one-cycle reboot request, and the identifier itself does not change. Any write to the lock slot sets the lock, and it stays set until reset. Two groups of three slots are passed straight through to external timers as select, field and data ports. The block does not implement the timers.

A single access state machine classifies each strobe during the cycle it is presented. For the following cycle it enters one of these states:
- `ST_IDLE`: no access.
- `ST_RD_ACK`: read accepted.
- `ST_RD_FAULT`: read rejected.
- `ST_WR_ACK`: write accepted.
- `ST_WR_FAULT`: write rejected.
- `ST_HALT`: halt requested.
- `ST_REBOOT`: reboot requested.

Transitions are taken from any state:
- No strobe goes to `ST_IDLE`.
- A malformed strobe goes to a fault state.
- A read of a mapped slot goes to `ST_RD_ACK`.
- A read of an unmapped slot goes to `ST_RD_FAULT`.
- A write to a writable slot goes to `ST_WR_ACK`.
- A write to a read-only or unmapped slot goes to `ST_WR_FAULT`.
- A write of the halt code to the command slot goes to `ST_HALT`.
- A write to the identifier slot goes to `ST_REBOOT`.

Every state except `ST_IDLE` lasts exactly one cycle unless another strobe follows.

Top module: `sysc_ctrl`

## Requirements
- R1: After reset the bus reads these values:
  - slot 31 (identifier): 0x10014D31
  - slot 29 (clock rate): 80000000
  - slot 30 (features): 0
  - slot 0 (strap inputs): 1
  - slot 16 (command): 1, where bit 0 is the ready bit
  - slots 1, 2, 20 and 21: 0

  The `gpio_out` and `gpio_inten` ports are 0 after reset.
- R2: Slot 1 (output word), slot 2 (interrupt-enable word) and slot 20 (scratch) read back the last value written. Slots 1 and 2 also drive `gpio_out` and `gpio_inten` from the cycle after the write.
- R3: Read data and `bus_rvalid` are registered. They are valid in the cycle after a read strobe. `bus_rvalid` is low in the cycle after any cycle with no read strobe.
- R4: Any write to slot 21 makes it read 1, whatever the data. Later writes never clear it; only reset does.
- R5: A write to slot 16 whose data bits [15:0] equal 0x000E makes `halt_req` high for the following cycle. Any other value raises nothing, and slot 16 still reads 1.
- R6: Any write to slot 31 makes `reboot_req` high for the following cycle. Slot 31 still reads 0x10014D31 afterwards.
- R7: Writes to slots 0, 29 and 30 leave their values unchanged. They raise `bus_err` for the following cycle.
- R8: A slot not listed in R1, R2 or R10 reads 0 and ignores writes. Any access to such a slot raises `bus_err` for the following cycle.
- R9: A strobe with `bus_be` not equal to 4'hF, or with `bus_addr[1:0]` not zero, changes nothing. It raises `bus_err` for the following cycle and reads 0. Such a strobe also selects no timer.
- R10: Timer t (t = 0, 1) owns slots 4t+4 to 4t+6. A strobe to one of these slots drives `timer_sel[t]` high during the same cycle, and `timer_field` carries address bits [3:2]. A read of such a slot returns `timer_rdata[32t+31:32t]` in the next cycle. `timer_we` and `timer_wdata` mirror the bus.
- R11: In any cycle at most one of `halt_req`, `reboot_req` and `bus_err` is high, and at most one bit of `timer_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address; bits [6:2] select the slot |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| bus_err | output | 1 | One-cycle access error pulse |
| gpio_out | output | 32 | Output word register |
| gpio_inten | output | 32 | Interrupt-enable word register |
| halt_req | output | 1 | One-cycle halt request |
| reboot_req | output | 1 | One-cycle reboot request |
| timer_sel | output | 2 | Per-timer select, combinational from the strobe |
| timer_field | output | 2 | Timer register field (address bits [3:2]) |
| timer_we | output | 1 | Timer write flag (mirrors bus_we) |
| timer_wdata | output | 32 | Timer write data (mirrors bus_wdata) |
| timer_rdata | input | 64 | Timer read words, 32 bits per timer |

## Verification
The assertions assume that `bus_sel`, `bus_we`, `bus_addr`, `bus_be` and `bus_wdata` are driven to known values in every cycle after reset, and that the past-cycle properties relate a pulse only to the strobe of the immediately preceding cycle. The stimulus drives every input at the falling edge, so each value is settled well before it is sampled. Read-back of the timer slots assumes `timer_rdata` is held steady from the strobe edge. The bench meets this by holding it at fixed constants. Random accesses are drawn over all 32 slots with mostly full byte enables. The halt code and misaligned or partial strobes are mixed in at low rates.

// File: rtl/sysc_pkg.sv
package sysc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned ADDR_W = IDX_W + 2;
    localparam int unsigned BE_W   = WORD_W / 8;

    localparam logic [IDX_W-1:0] IX_STRAP   = 5'd0;
    localparam logic [IDX_W-1:0] IX_OUTW    = 5'd1;
    localparam logic [IDX_W-1:0] IX_IENW    = 5'd2;
    localparam logic [IDX_W-1:0] IX_CMD     = 5'd16;
    localparam logic [IDX_W-1:0] IX_SCRATCH = 5'd20;
    localparam logic [IDX_W-1:0] IX_LOCK    = 5'd21;
    localparam logic [IDX_W-1:0] IX_CLKRATE = 5'd29;
    localparam logic [IDX_W-1:0] IX_FEATURE = 5'd30;
    localparam logic [IDX_W-1:0] IX_IDENT   = 5'd31;

    localparam logic [15:0] CMD_HALT_CODE = 16'h000E;
    localparam logic [WORD_W-1:0] CMD_READY = 32'h0000_0001;

    typedef enum logic [3:0] {
        K_NONE,
        K_STRAP,
        K_OUTW,
        K_IENW,
        K_TIMER,
        K_CMD,
        K_SCRATCH,
        K_LOCK,
        K_CLKRATE,
        K_FEATURE,
        K_IDENT
    } slot_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACK,
        ST_RD_FAULT,
        ST_WR_ACK,
        ST_WR_FAULT,
        ST_HALT,
        ST_REBOOT
    } acc_state_e;

endpackage

// File: rtl/sysc_decode.sv
module sysc_decode
    import sysc_pkg::*;
#(
    parameter int unsigned NT = 2
) (
    input  logic [IDX_W-1:0] idx,
    output slot_kind_e       kind,
    output logic [NT-1:0]    tmr_hit,
    output logic [1:0]       tmr_field
);

    localparam int unsigned GRP_W = IDX_W - 2;

    logic [GRP_W-1:0] grp;
    assign grp       = idx[IDX_W-1:2];
    assign tmr_field = idx[1:0];

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        assign tmr_hit[t] = (grp == GRP_W'(t + 1)) && (idx[1:0] != 2'd3);
    end

    always_comb begin
        kind = K_NONE;
        unique case (idx)
            IX_STRAP:   kind = K_STRAP;
            IX_OUTW:    kind = K_OUTW;
            IX_IENW:    kind = K_IENW;
            IX_CMD:     kind = K_CMD;
            IX_SCRATCH: kind = K_SCRATCH;
            IX_LOCK:    kind = K_LOCK;
            IX_CLKRATE: kind = K_CLKRATE;
            IX_FEATURE: kind = K_FEATURE;
            IX_IDENT:   kind = K_IDENT;
            default:    kind = (|tmr_hit) ? K_TIMER : K_NONE;
        endcase
    end

endmodule

// File: rtl/sysc_regs.sv
module sysc_regs
    import sysc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_kind_e        kind,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] outw_q,
    output logic [WORD_W-1:0] ienw_q,
    output logic [WORD_W-1:0] scratch_q,
    output logic              lock_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outw_q    <= '0;
            ienw_q    <= '0;
            scratch_q <= '0;
            lock_q    <= 1'b0;
        end else if (wr_en) begin
            unique case (kind)
                K_OUTW:    outw_q    <= wdata;
                K_IENW:    ienw_q    <= wdata;
                K_SCRATCH: scratch_q <= wdata;
                K_LOCK:    lock_q    <= 1'b1;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/sysc_access_fsm.sv
module sysc_access_fsm
    import sysc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       we,
    input  logic       full,
    input  slot_kind_e kind,
    input  logic [15:0] cmd_lo,
    output logic       rd_valid,
    output logic       err,
    output logic       halt,
    output logic       reboot
);

    acc_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (!acc) begin
            state_d = ST_IDLE;
        end else if (!full) begin
            state_d = we ? ST_WR_FAULT : ST_RD_FAULT;
        end else if (!we) begin
            state_d = (kind == K_NONE) ? ST_RD_FAULT : ST_RD_ACK;
        end else begin
            unique case (kind)
                K_NONE, K_STRAP, K_CLKRATE, K_FEATURE: state_d = ST_WR_FAULT;
                K_IDENT: state_d = ST_REBOOT;
                K_CMD:   state_d = (cmd_lo == CMD_HALT_CODE) ? ST_HALT : ST_WR_ACK;
                default: state_d = ST_WR_ACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_valid = 1'b0;
        err      = 1'b0;
        halt     = 1'b0;
        reboot   = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_RD_ACK:   rd_valid = 1'b1;
            ST_RD_FAULT: begin rd_valid = 1'b1; err = 1'b1; end
            ST_WR_ACK:   ;
            ST_WR_FAULT: err = 1'b1;
            ST_HALT:     halt = 1'b1;
            ST_REBOOT:   reboot = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/sysc_ctrl.sv
module sysc_ctrl
    import sysc_pkg::*;
#(
    parameter int unsigned NT       = 2,
    parameter logic [31:0] STRAP_V  = 32'h0000_0001,
    parameter logic [31:0] CLK_HZ   = 32'd80000000,
    parameter logic [31:0] FEAT_V   = 32'h0000_0000,
    parameter logic [31:0] IDENT_V  = 32'h1001_4D31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [6:0]         bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               bus_err,
    output logic [31:0]        gpio_out,
    output logic [31:0]        gpio_inten,
    output logic               halt_req,
    output logic               reboot_req,
    output logic [NT-1:0]      timer_sel,
    output logic [1:0]         timer_field,
    output logic               timer_we,
    output logic [31:0]        timer_wdata,
    input  logic [NT*32-1:0]   timer_rdata
);

    localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

    logic [IDX_W-1:0]  idx;
    logic              full;
    slot_kind_e        kind;
    logic [NT-1:0]     tmr_hit;
    logic [WORD_W-1:0] outw_q, ienw_q, scratch_q;
    logic              lock_q;
    logic [WORD_W-1:0] tmr_word;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    assign idx  = bus_addr[ADDR_W-1:2];
    assign full = (bus_be == BE_FULL) && (bus_addr[1:0] == 2'b00);

    sysc_decode #(.NT(NT)) u_dec (
        .idx       (idx),
        .kind      (kind),
        .tmr_hit   (tmr_hit),
        .tmr_field (timer_field)
    );

    sysc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_sel && bus_we && full),
        .kind      (kind),
        .wdata     (bus_wdata),
        .outw_q    (outw_q),
        .ienw_q    (ienw_q),
        .scratch_q (scratch_q),
        .lock_q    (lock_q)
    );

    sysc_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (bus_sel),
        .we       (bus_we),
        .full     (full),
        .kind     (kind),
        .cmd_lo   (bus_wdata[15:0]),
        .rd_valid (bus_rvalid),
        .err      (bus_err),
        .halt     (halt_req),
        .reboot   (reboot_req)
    );

    always_comb begin
        tmr_word = '0;
        for (int t = 0; t < NT; t++) begin
            if (tmr_hit[t]) tmr_word = timer_rdata[t*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (kind)
            K_STRAP:   rd_mux = STRAP_V;
            K_OUTW:    rd_mux = outw_q;
            K_IENW:    rd_mux = ienw_q;
            K_TIMER:   rd_mux = tmr_word;
            K_CMD:     rd_mux = CMD_READY;
            K_SCRATCH: rd_mux = scratch_q;
            K_LOCK:    rd_mux = {{(WORD_W-1){1'b0}}, lock_q};
            K_CLKRATE: rd_mux = CLK_HZ;
            K_FEATURE: rd_mux = FEAT_V;
            K_IDENT:   rd_mux = IDENT_V;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (bus_sel && !bus_we) rdata_q <= full ? rd_mux : '0;
    end

    assign bus_rdata   = rdata_q;
    assign gpio_out    = outw_q;
    assign gpio_inten  = ienw_q;
    assign timer_sel   = (bus_sel && full) ? tmr_hit : '0;
    assign timer_we    = bus_we;
    assign timer_wdata = bus_wdata;

endmodule

// File: rtl/sysc_ctrl_checker.sv
module sysc_ctrl_checker #(
    parameter int unsigned NT      = 2,
    parameter logic [31:0] IDENT_V = 32'h1001_4D31
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [6:0]    bus_addr,
    input logic [3:0]    bus_be,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          bus_rvalid,
    input logic          bus_err,
    input logic          halt_req,
    input logic          reboot_req,
    input logic [NT-1:0] timer_sel,
    input logic          lock_q
);

    logic ok_shape;
    assign ok_shape = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);

    p_rvalid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);

    p_rvalid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> !bus_rvalid);

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    p_halt_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(bus_sel && bus_we && ok_shape &&
                           bus_addr[6:2] == 5'd16 && bus_wdata[15:0] == 16'h000E));

    p_reboot_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |-> $past(bus_sel && bus_we && ok_shape && bus_addr[6:2] == 5'd31));

    p_ident_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && ok_shape && bus_addr[6:2] == 5'd31) |=> (bus_rdata == IDENT_V));

    p_shape_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !ok_shape) |=> bus_err);

    p_timer_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(timer_sel));

    p_pulse_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_req, reboot_req, bus_err}));

endmodule

bind sysc_ctrl sysc_ctrl_checker #(.NT(NT), .IDENT_V(IDENT_V)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .halt_req   (halt_req),
    .reboot_req (reboot_req),
    .timer_sel  (timer_sel),
    .lock_q     (lock_q)
);

// File: tb/sysc_ctrl_test.sv
module sysc_ctrl_test;

    localparam int NT = 2;
    localparam logic [31:0] T0_WORD = 32'h7100_0000;
    localparam logic [31:0] T1_WORD = 32'h7100_0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [3:0]    bus_be = 4'hF;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, bus_err;
    logic [31:0]   gpio_out, gpio_inten;
    logic          halt_req, reboot_req;
    logic [NT-1:0] timer_sel;
    logic [1:0]    timer_field;
    logic          timer_we;
    logic [31:0]   timer_wdata;
    logic [NT*32-1:0] timer_rdata = {T1_WORD, T0_WORD};

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [31:0] m_out = '0, m_ien = '0, m_scr = '0;
    logic        m_lock = 1'b0;

    sysc_ctrl #(.NT(NT)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .gpio_out(gpio_out), .gpio_inten(gpio_inten),
        .halt_req(halt_req), .reboot_req(reboot_req),
        .timer_sel(timer_sel), .timer_field(timer_field),
        .timer_we(timer_we), .timer_wdata(timer_wdata),
        .timer_rdata(timer_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, act=%0d exp<=100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int tmr_of(input logic [4:0] i);
        for (int t = 0; t < NT; t++)
            if (i[4:2] == 3'(t + 1) && i[1:0] != 2'd3) return t;
        return -1;
    endfunction

    function automatic bit mapped(input logic [4:0] i);
        if (tmr_of(i) >= 0) return 1'b1;
        return (i == 0 || i == 1 || i == 2 || i == 16 || i == 20 ||
                i == 21 || i == 29 || i == 30 || i == 31);
    endfunction

    function automatic bit read_only(input logic [4:0] i);
        return (i == 0 || i == 29 || i == 30);
    endfunction

    function automatic logic [31:0] exp_word(input logic [4:0] i);
        int t;
        t = tmr_of(i);
        if (t == 0) return T0_WORD;
        if (t == 1) return T1_WORD;
        case (i)
            5'd0:  return 32'h1;
            5'd1:  return m_out;
            5'd2:  return m_ien;
            5'd16: return 32'h1;
            5'd20: return m_scr;
            5'd21: return {31'd0, m_lock};
            5'd29: return 32'd80000000;
            5'd30: return 32'h0;
            5'd31: return 32'h1001_4D31;
            default: return 32'h0;
        endcase
    endfunction

    task automatic acc(input logic we, input logic [4:0] i, input logic [31:0] wd,
                       input logic [3:0] be, input logic [1:0] lo);
        bit ok, is_halt, is_reboot, is_err;
        int t;
        logic [31:0] exp_rd;
        logic [NT-1:0] exp_sel;
        ok = (be == 4'hF) && (lo == 2'b00);
        t = tmr_of(i);
        exp_sel = '0;
        if (ok && t >= 0) exp_sel[t] = 1'b1;
        exp_rd = ok ? exp_word(i) : 32'h0;
        is_halt = ok && we && i == 5'd16 && wd[15:0] == 16'h000E;
        is_reboot = ok && we && i == 5'd31;
        is_err = !ok || !mapped(i) || (we && read_only(i));
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = {i, lo}; bus_wdata = wd; bus_be = be;
        #1;
        chk("R10 timer_sel", 32'(timer_sel), 32'(exp_sel));
        if (exp_sel != '0) begin
            chk("R10 timer_field", 32'(timer_field), 32'(i[1:0]));
            chk("R10 timer_we", 32'(timer_we), 32'(we));
            chk("R10 timer_wdata", timer_wdata, wd);
        end
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R3 rvalid", 32'(bus_rvalid), 32'(!we));
        if (!we) chk(t >= 0 ? "R10 rdata" : "R3 rdata", bus_rdata, exp_rd);
        chk("R5 halt_req", 32'(halt_req), 32'(is_halt));
        chk("R6 reboot_req", 32'(reboot_req), 32'(is_reboot));
        chk(!ok ? "R9 bus_err" : "R8 bus_err", 32'(bus_err), 32'(is_err));
        chk("R11 exclusive", 32'($countones({halt_req, reboot_req, bus_err})), 32'(is_err || is_halt || is_reboot));
        if (ok && we) begin
            case (i)
                5'd1:  m_out = wd;
                5'd2:  m_ien = wd;
                5'd20: m_scr = wd;
                5'd21: m_lock = 1'b1;
                default: ;
            endcase
        end
        chk("R2 gpio_out", gpio_out, m_out);
        chk("R2 gpio_inten", gpio_inten, m_ien);
    endtask

    task automatic rd(input logic [4:0] i);
        acc(1'b0, i, 32'h0, 4'hF, 2'b00);
    endtask

    task automatic wr(input logic [4:0] i, input logic [31:0] d);
        acc(1'b1, i, d, 4'hF, 2'b00);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1 gpio_out", gpio_out, 32'h0);
        chk("R1 gpio_inten", gpio_inten, 32'h0);
        chk("R1 err", 32'(bus_err), 32'h0);
        rd(5'd31); chk("R1 ident", bus_rdata, 32'h1001_4D31);
        rd(5'd29); chk("R1 clock", bus_rdata, 32'd80000000);
        rd(5'd30); chk("R1 features", bus_rdata, 32'h0);
        rd(5'd0);  chk("R1 strap", bus_rdata, 32'h1);
        rd(5'd16); chk("R1 cmd ready", bus_rdata, 32'h1);
        rd(5'd1); rd(5'd2); rd(5'd20); rd(5'd21);
        // R2
        wr(5'd1, 32'hDEAD_BEEF); rd(5'd1);
        wr(5'd2, 32'h0000_00F0); rd(5'd2);
        wr(5'd20, 32'h1234_5678); rd(5'd20);
        // R4
        wr(5'd21, 32'h0); rd(5'd21); chk("R4 lock set", bus_rdata, 32'h1);
        wr(5'd21, 32'h0); rd(5'd21); chk("R4 lock held", bus_rdata, 32'h1);
        // R5
        wr(5'd16, 32'hABCD_000E);
        wr(5'd16, 32'h0000_000F);
        rd(5'd16); chk("R5 cmd still ready", bus_rdata, 32'h1);
        // R6
        wr(5'd31, 32'h0);
        rd(5'd31); chk("R6 ident kept", bus_rdata, 32'h1001_4D31);
        // R7
        wr(5'd0, 32'hFFFF_FFFF); rd(5'd0); chk("R7 strap kept", bus_rdata, 32'h1);
        wr(5'd29, 32'h5); rd(5'd29); chk("R7 clock kept", bus_rdata, 32'd80000000);
        wr(5'd30, 32'h5); rd(5'd30); chk("R7 features kept", bus_rdata, 32'h0);
        // R8
        wr(5'd3, 32'h1); rd(5'd3); chk("R8 unmapped zero", bus_rdata, 32'h0);
        rd(5'd7); rd(5'd12); wr(5'd25, 32'h9);
        // R9
        acc(1'b1, 5'd20, 32'hFFFF_0000, 4'h3, 2'b00);
        acc(1'b1, 5'd20, 32'hFFFF_0000, 4'hF, 2'b10);
        rd(5'd20); chk("R9 scratch kept", bus_rdata, 32'h1234_5678);
        acc(1'b0, 5'd1, 32'h0, 4'h1, 2'b00);
        acc(1'b0, 5'd5, 32'h0, 4'hF, 2'b01);
        // R10
        rd(5'd4); rd(5'd6); rd(5'd9); wr(5'd8, 32'h55); wr(5'd10, 32'h66);
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [4:0] i;
            logic [31:0] d;
            logic [3:0] be;
            logic [1:0] lo;
            i = 5'($urandom_range(0, 31));
            d = $urandom();
            if ($urandom_range(0, 7) == 0) d[15:0] = 16'h000E;
            be = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
            lo = ($urandom_range(0, 11) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            acc(1'($urandom_range(0, 1)), i, d, be, lo);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule